// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus whose data line is held low by a slave that lost track of an aborted transfer. A protocol engine or error handler raises a one-cycle start request. If the sensed SDA level is already high, the block reports completion at once and touches nothing. If SDA is low, the block clocks SCL by overriding it low for one half-period and then releasing it for one half-period. It samples SDA at the end of every released half and stops pulsing as soon as the slave lets go, or when a pulse limit is reached.

After pulsing, the block always closes with a forced stop condition. It overrides both lines low for one half-period, then releases SCL while still holding SDA for one half-period, and then releases SDA. The rising SDA edge while SCL is high is the stop. The half-period timing tick is produced inside the block from a parameter given in system clock cycles. A one-cycle done pulse ends the sequence, and a status bit reports whether SDA was seen released.

Override outputs mean "drive this line low" and go to the open-drain pad logic. The block carries no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `bus_recovery`

## Requirements
- R1: After reset, scl_ovr_o, sda_ovr_o and done_o are 0.
- R2: A start with sda_in_i high raises done_o in the next cycle with released_o = 1, and the block asserts no override at all.
- R3: A start with sda_in_i low begins pulsing in the next cycle. Each pulse holds scl_ovr_o = 1 for HALF_CYC cycles and then 0 for HALF_CYC cycles.
- R4: sda_in_i is sampled at the last cycle of each released half. The first pulse that ends with SDA high is the last pulse.
- R5: No more than MAX_PULSES pulses are issued. If SDA is still low after the last one, released_o = 0. If SDA is high at the end of the final allowed pulse, released_o = 1.
- R6: The stop phase asserts sda_ovr_o and scl_ovr_o together for HALF_CYC cycles, then sda_ovr_o alone for HALF_CYC cycles, then releases both. sda_ovr_o only rises while scl_ovr_o is 1.
- R7: done_o is a single-cycle pulse. After n > 0 pulses it is high exactly 2·HALF_CYC·(n+1) cycles after the cycle in which start was captured. released_o holds its value until the next accepted start.
- R8: A start request while a sequence is running is ignored and changes neither the timing nor the result.
- R9: sda_ovr_o is never asserted during the pulsing phase or when SDA was already high at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Recovery request, one cycle |
| sda_in_i | input | 1 | Synchronised SDA level sensed at the pad |
| scl_ovr_o | output | 1 | Force SCL low |
| sda_ovr_o | output | 1 | Force SDA low |
| done_o | output | 1 | Sequence finished, one-cycle pulse |
| released_o | output | 1 | SDA was seen high before the stop phase |

## Verification
The bench sweeps the number of pulses after which a modelled slave lets SDA go, from zero (already free) to beyond the pulse limit. Its targets are an off-by-one pulse limit, which would shift done and the stop edges by 2·HALF_CYC cycles, and sampling SDA in the wrong half, which would add one extra pulse. The release on exactly the last allowed pulse checks that a released line wins over the limit; a design that gave the limit priority would report released_o = 0. Start requests injected mid-sequence must not restart the timer, and the stop edges are timed against SCL so that a swapped ordering would create a start condition instead of a stop.

// File: rtl/bus_recovery_pkg.sv
package bus_recovery_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SCL_LOW    = 3'd1,
    ST_SCL_REL    = 3'd2,
    ST_STOP_SETUP = 3'd3,
    ST_STOP_HOLD  = 3'd4
  } rec_state_t;
endpackage

// File: rtl/rec_half_timer.sv
module rec_half_timer #(
  parameter int HALF_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/rec_pulse_counter.sv
module rec_pulse_counter #(
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_PULSES - 1);

  logic [CW-1:0] cnt_q;

  assign last = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PULSES));
endmodule

// File: rtl/rec_fsm.sv
module rec_fsm
  import bus_recovery_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_in_i,
  input  logic tick,
  input  logic last,
  output logic restart,
  output logic cnt_clear,
  output logic cnt_inc,
  output logic scl_ovr_o,
  output logic sda_ovr_o,
  output logic done_o,
  output logic released_o
);
  rec_state_t state_q, state_d;
  logic done_q, done_d;
  logic rel_q, rel_d;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    rel_d     = rel_q;
    cnt_clear = 1'b0;
    cnt_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (sda_in_i) begin
            done_d = 1'b1;
            rel_d  = 1'b1;
          end else begin
            state_d   = ST_SCL_LOW;
            rel_d     = 1'b0;
            cnt_clear = 1'b1;
          end
        end
      end
      ST_SCL_LOW: if (tick) state_d = ST_SCL_REL;
      ST_SCL_REL: begin
        if (tick) begin
          cnt_inc = 1'b1;
          if (sda_in_i) begin
            state_d = ST_STOP_SETUP;
            rel_d   = 1'b1;
          end else if (last) begin
            state_d = ST_STOP_SETUP;
          end else begin
            state_d = ST_SCL_LOW;
          end
        end
      end
      ST_STOP_SETUP: if (tick) state_d = ST_STOP_HOLD;
      ST_STOP_HOLD: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      rel_q   <= rel_d;
    end
  end

  assign restart    = (state_q == ST_IDLE) || tick;
  assign scl_ovr_o  = (state_q == ST_SCL_LOW) || (state_q == ST_STOP_SETUP);
  assign sda_ovr_o  = (state_q == ST_STOP_SETUP) || (state_q == ST_STOP_HOLD);
  assign done_o     = done_q;
  assign released_o = rel_q;

  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_ovr_o && !sda_ovr_o));
  a_r6_stop_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_ovr_o) |-> scl_ovr_o);
  a_r6_stop_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_ovr_o) |-> done_o);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_rel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && state_q == ST_IDLE) |=> $stable(released_o));
endmodule

// File: rtl/bus_recovery.sv
module bus_recovery #(
  parameter int HALF_CYC   = 600,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_in_i,
  output logic scl_ovr_o,
  output logic sda_ovr_o,
  output logic done_o,
  output logic released_o
);
  logic tick, restart, last, cnt_clear, cnt_inc;

  rec_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  rec_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_count (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .inc(cnt_inc), .last(last)
  );

  rec_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_in_i(sda_in_i),
    .tick(tick), .last(last), .restart(restart), .cnt_clear(cnt_clear),
    .cnt_inc(cnt_inc), .scl_ovr_o(scl_ovr_o), .sda_ovr_o(sda_ovr_o),
    .done_o(done_o), .released_o(released_o)
  );
endmodule

// File: tb/tb_bus_recovery.sv
module tb_bus_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int H   = 3;
  localparam int MAXP = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stuck = 1'b0;
  logic sda_in, scl_ovr, sda_ovr, done, released;
  int n_checks = 0, n_errs = 0;
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = !stuck && !sda_ovr;

  bus_recovery #(.HALF_CYC(H), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sda_in_i(sda_in),
    .scl_ovr_o(scl_ovr), .sda_ovr_o(sda_ovr), .done_o(done), .released_o(released)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic run(int r, bit poke);
    int n, exp_done, pulses, hi_start, bad_w, sda_rise, scl_fall, sda_fall;
    int done_cnt, done_cyc, rel_at, scl_at_rise;
    logic prev_scl, prev_sda;
    n = (r == 0) ? 0 : ((r < MAXP) ? r : MAXP);
    exp_done = (n == 0) ? 0 : 2 * H * (n + 1);
    pulses = 0; hi_start = 0; bad_w = 0; sda_rise = -1; scl_fall = -1;
    sda_fall = -1; done_cnt = 0; done_cyc = -1; rel_at = -1; scl_at_rise = -1;
    prev_scl = 1'b0; prev_sda = 1'b0;
    stuck = (r > 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 2 * H * (MAXP + 1) + 12; cyc++) begin
      start = poke && (cyc == 2 * H + 1);
      if (scl_ovr && !prev_scl && !sda_ovr) begin pulses++; hi_start = cyc; end
      if (!scl_ovr && prev_scl && !sda_ovr && (cyc - hi_start) != H) bad_w++;
      if (sda_ovr && !prev_sda) begin sda_rise = cyc; scl_at_rise = scl_ovr; end
      if (!scl_ovr && prev_scl && sda_ovr) scl_fall = cyc;
      if (!sda_ovr && prev_sda) sda_fall = cyc;
      if (done) begin
        done_cnt++;
        if (done_cyc < 0) begin done_cyc = cyc; rel_at = released; end
      end
      if (stuck && !scl_ovr && pulses >= r) stuck = 1'b0;
      prev_scl = scl_ovr; prev_sda = sda_ovr;
      @(negedge clk);
    end
    start = 1'b0;
    stuck = 1'b0;
    check($sformatf("R7 done cycle r=%0d", r), done_cyc, exp_done);
    check($sformatf("R7 single done r=%0d", r), done_cnt, 1);
    check($sformatf("R4 R5 pulse count r=%0d", r), pulses, n);
    check($sformatf("R3 pulse width r=%0d", r), bad_w, 0);
    check($sformatf("R5 released r=%0d", r), rel_at, (r <= MAXP) ? 1 : 0);
    check($sformatf("R7 released held r=%0d", r), released, (r <= MAXP) ? 1 : 0);
    if (poke) check($sformatf("R8 start ignored r=%0d", r), done_cyc, exp_done);
    if (n == 0) begin
      check("R2 R9 no sda override", sda_rise, -1);
    end else begin
      check($sformatf("R6 R9 sda rise r=%0d", r), sda_rise, 2 * H * n);
      check($sformatf("R6 scl high at sda rise r=%0d", r), scl_at_rise, 1);
      check($sformatf("R6 scl release r=%0d", r), scl_fall, 2 * H * n + H);
      check($sformatf("R6 sda release r=%0d", r), sda_fall, 2 * H * n + 2 * H);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset scl_ovr", scl_ovr, 0);
    check("R1 reset sda_ovr", sda_ovr, 0);
    check("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r <= MAXP + 2; r++) run(r, 1'b0);
    run(3, 1'b1);
    run(MAXP + 2, 1'b1);
    run(0, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule